// File: doc/BRIEF.md
# Calibration Trigger Sequencer

This block sits in front of the self-calibration logic of a clock-recovery loop. It watches a single shared control pin. Holding the pin high puts the loop into power-down, and releasing it asks for a calibration. The pin is sampled on a local timing clock through a two-stage synchronizer. The synchronized level drives the power-down output directly.

A falling edge counts as a calibration command only when the pin has been high for at least `MIN_HIGH_CYC` local clock cycles beforehand. With a 100 MHz local clock, the default of 100 cycles is one microsecond. A shorter high pulse only powers the loop down briefly and starts nothing.

A command waits in a pending state until the reference clock is reported valid. It then fires a one-cycle start pulse and raises a busy flag, which stays up until the calibration engine acknowledges. After the acknowledge the block gives a one-cycle done pulse. The calibration that follows power-up is requested the same way: the pin is held high while supplies settle and is then released.

The state machine has the following states:
- IDLE: the pin is low.
- PDOWN: the pin is high.
- PEND: a qualified command is waiting for the reference clock.
- START: the one-cycle start pulse.
- BUSY: waiting for the acknowledge.
- DONE: the one-cycle done pulse.

The state machine has the following transitions:
- IDLE→PDOWN when the synchronized pin is high.
- PDOWN→START on a qualified fall while the reference is valid.
- PDOWN→PEND on a qualified fall while the reference is invalid.
- PDOWN→IDLE on an unqualified fall.
- PEND→START when the reference becomes valid.
- PEND→PDOWN when the pin rises again.
- START→BUSY.
- BUSY→DONE on the acknowledge.
- DONE→IDLE.
- START, BUSY or DONE→PDOWN whenever the synchronized pin is high. This is an abort.

Top module: `caltrig_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `pwr_down`, `cal_start`, `cal_busy` and `cal_done` are all 0.
- R2: `pwr_down` equals the pin level delayed by two clock edges: a pin change made before edge n is visible after edge n+1.
- R3: A high pulse of `MIN_HIGH_CYC-1` cycles or fewer never produces `cal_start`, and the block returns to its idle state (all outputs 0).
- R4: After a qualified fall with `ref_ok`=1, `cal_start` is 1 for exactly one cycle, visible after the third clock edge following the pin's falling edge.
- R5: A high pulse of exactly `MIN_HIGH_CYC` cycles qualifies as a command.
- R6: A qualified fall while `ref_ok`=0 produces no `cal_start`. `cal_start` appears after the first clock edge at which `ref_ok` is sampled 1.
- R7: A pending command is cancelled if the pin goes high again before `ref_ok` becomes valid. No `cal_start` follows, and a later qualified fall is handled normally.
- R8: `cal_busy` is 1 from the `cal_start` cycle until the edge that samples `cal_ack`=1. After that edge `cal_busy` is 0 and `cal_done` is 1 for exactly one cycle.
- R9: If the pin goes high while a calibration is busy, `cal_busy` falls one edge after `pwr_down` rises, and no `cal_done` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdcal_in | input | 1 | Combined power-down / calibrate pin, asynchronous |
| ref_ok | input | 1 | Reference clock reported valid, synchronous to clk |
| cal_ack | input | 1 | Calibration finished, from the calibration engine |
| pwr_down | output | 1 | Hold the loop in power-down |
| cal_start | output | 1 | One-cycle calibration request |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle completion pulse |

## Verification
The pin is driven with several high-pulse lengths:
- One cycle short of the minimum and exactly the minimum. These separate the two sides of the qualification boundary.
- A long pulse that re-arms the command after a cancellation. This shows that the counter restarts cleanly.

The reference-valid input is held low across a qualified fall and then raised. This tells a pending command apart from one that is dropped. Raising the pin again during the pending and busy phases shows that both cancel paths return to power-down without any start or done pulse. Acknowledges that arrive with the pin low check the busy/done handover cycle by cycle.

// File: rtl/caltrig_pkg.sv
package caltrig_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PDOWN = 3'd1,
        ST_PEND  = 3'd2,
        ST_START = 3'd3,
        ST_BUSY  = 3'd4,
        ST_DONE  = 3'd5
    } cal_state_t;
endpackage

// File: rtl/caltrig_sync.sv
module caltrig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/caltrig_hightimer.sv
module caltrig_hightimer #(
    parameter int MIN_HIGH_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall,
    output logic qual
);
    localparam int CW = $clog2(MIN_HIGH_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_HIGH_CYC);

    logic [CW-1:0] high_cnt;
    logic          lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt <= '0;
            lvl_d    <= 1'b0;
        end else begin
            lvl_d <= lvl;
            if (!lvl)                high_cnt <= '0;
            else if (high_cnt < LIMIT) high_cnt <= high_cnt + 1'b1;
        end
    end

    assign fall = lvl_d & ~lvl;
    assign qual = (high_cnt >= LIMIT);

    // R3: the saturating counter never passes its limit
    a_r3_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        high_cnt <= LIMIT);
    // R3: a low level clears the count on the next edge
    a_r3_cnt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl |=> (high_cnt == '0));
endmodule

// File: rtl/caltrig_seq.sv
module caltrig_seq
    import caltrig_pkg::*;
#(
    parameter int MIN_HIGH_CYC = 100,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdcal_in,
    input  logic ref_ok,
    input  logic cal_ack,
    output logic pwr_down,
    output logic cal_start,
    output logic cal_busy,
    output logic cal_done
);
    cal_state_t state, state_nx;
    logic       pin_s;
    logic       pin_fall;
    logic       pin_qual;

    caltrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pdcal_in),
        .q_sync  (pin_s)
    );

    caltrig_hightimer #(.MIN_HIGH_CYC(MIN_HIGH_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_s),
        .fall  (pin_fall),
        .qual  (pin_qual)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (pin_s) state_nx = ST_PDOWN;
            end
            ST_PDOWN: begin
                if (pin_fall) begin
                    if (!pin_qual)  state_nx = ST_IDLE;
                    else if (ref_ok) state_nx = ST_START;
                    else             state_nx = ST_PEND;
                end
            end
            ST_PEND: begin
                if (pin_s)       state_nx = ST_PDOWN;
                else if (ref_ok) state_nx = ST_START;
            end
            ST_START: begin
                state_nx = pin_s ? ST_PDOWN : ST_BUSY;
            end
            ST_BUSY: begin
                if (pin_s)        state_nx = ST_PDOWN;
                else if (cal_ack) state_nx = ST_DONE;
            end
            ST_DONE: begin
                state_nx = pin_s ? ST_PDOWN : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pwr_down  = pin_s;
        cal_start = (state == ST_START);
        cal_busy  = (state == ST_START) || (state == ST_BUSY);
        cal_done  = (state == ST_DONE);
    end

    // R4: start is a single-cycle pulse
    a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);
    // R6: a start always follows a cycle in which the reference was valid
    a_r6_start_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_start) |-> $past(ref_ok));
    // R8: busy holds while no acknowledge and no power-down
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && !cal_ack && !pwr_down) |=> cal_busy);
    // R8: acknowledge during busy yields done and drops busy
    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && cal_ack && !pwr_down) |=> (cal_done && !cal_busy));
    // R9: power-down suppresses start and busy on the next cycle
    a_r9_pd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!cal_start && !cal_busy));
    // R8: done is a single-cycle pulse
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);
endmodule

// File: tb/caltrig_seq_bench.sv
`timescale 1ns/1ps
module caltrig_seq_bench;
    localparam int MINC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdcal_in = 1'b0;
    logic ref_ok = 1'b1;
    logic cal_ack = 1'b0;
    logic pwr_down, cal_start, cal_busy, cal_done;

    int checks = 0;
    int failures = 0;
    int n_start = 0;
    int n_done = 0;

    always #2 clk = ~clk;

    caltrig_seq #(.MIN_HIGH_CYC(MINC)) u_caltrig_seq (
        .clk(clk), .rst_n(rst_n), .pdcal_in(pdcal_in), .ref_ok(ref_ok),
        .cal_ack(cal_ack), .pwr_down(pwr_down), .cal_start(cal_start),
        .cal_busy(cal_busy), .cal_done(cal_done)
    );

    always @(negedge clk) begin
        if (cal_start) n_start++;
        if (cal_done)  n_done++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // pin high for k cycles, returns at the negedge where the pin drops
    task automatic hi_pulse(input int k);
        @(negedge clk) pdcal_in = 1'b1;
        repeat (k) @(negedge clk);
        pdcal_in = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk) cal_ack = 1'b1;
        tick(1);
        chk(cal_done == 1'b1, "R8 done after ack", cal_done, 1);
        chk(cal_busy == 1'b0, "R8 busy low after ack", cal_busy, 0);
        @(negedge clk) cal_ack = 1'b0;
        tick(1);
        chk(cal_done == 1'b0, "R8 done one cycle", cal_done, 0);
    endtask

    task automatic t_reset();
        tick(3);
        chk({pwr_down, cal_start, cal_busy, cal_done} == 4'b0, "R1 outputs in reset",
            {pwr_down, cal_start, cal_busy, cal_done}, 0);
        @(negedge clk) rst_n = 1'b1;
        tick(2);
        chk({pwr_down, cal_start, cal_busy, cal_done} == 4'b0, "R1 outputs after reset",
            {pwr_down, cal_start, cal_busy, cal_done}, 0);
    endtask

    task automatic t_pd_follow();
        @(negedge clk) pdcal_in = 1'b1;
        tick(1);
        chk(pwr_down == 1'b0, "R2 pwr_down not yet", pwr_down, 0);
        tick(1);
        chk(pwr_down == 1'b1, "R2 pwr_down after two edges", pwr_down, 1);
        @(negedge clk) pdcal_in = 1'b0;
        tick(2);
        chk(pwr_down == 1'b0, "R2 pwr_down released", pwr_down, 0);
        tick(6);
    endtask

    task automatic t_short();
        int s0 = n_start;
        hi_pulse(MINC - 1);
        tick(8);
        chk(n_start == s0, "R3 short pulse no start", n_start - s0, 0);
        chk({pwr_down, cal_busy, cal_done} == 3'b0, "R3 back to idle",
            {pwr_down, cal_busy, cal_done}, 0);
    endtask

    task automatic t_exact();
        int s0 = n_start;
        hi_pulse(MINC);
        tick(2);
        chk(cal_start == 1'b0, "R4 start not early", cal_start, 0);
        tick(1);
        chk(cal_start == 1'b1, "R5 exact-minimum pulse starts", cal_start, 1);
        chk(cal_busy == 1'b1, "R8 busy with start", cal_busy, 1);
        tick(1);
        chk(cal_start == 1'b0, "R4 start single cycle", cal_start, 0);
        tick(4);
        chk(cal_busy == 1'b1, "R8 busy holds", cal_busy, 1);
        chk(n_start - s0 == 1, "R4 one start", n_start - s0, 1);
        do_ack();
    endtask

    task automatic t_pending();
        int s0 = n_start;
        ref_ok = 1'b0;
        hi_pulse(MINC + 5);
        tick(8);
        chk(n_start == s0, "R6 no start while ref invalid", n_start - s0, 0);
        chk(cal_busy == 1'b0, "R6 not busy while pending", cal_busy, 0);
        @(negedge clk) ref_ok = 1'b1;
        tick(1);
        chk(cal_start == 1'b1, "R6 start after ref valid", cal_start, 1);
        tick(1);
        do_ack();
    endtask

    task automatic t_cancel();
        int s0 = n_start;
        ref_ok = 1'b0;
        hi_pulse(MINC);
        tick(5);
        @(negedge clk) pdcal_in = 1'b1;
        tick(3);
        @(negedge clk) ref_ok = 1'b1;
        tick(4);
        chk(n_start == s0, "R7 cancelled no start", n_start - s0, 0);
        chk(pwr_down == 1'b1, "R7 back in power-down", pwr_down, 1);
        repeat (MINC) @(negedge clk);
        pdcal_in = 1'b0;
        tick(3);
        chk(cal_start == 1'b1, "R7 later command works", cal_start, 1);
        tick(1);
        do_ack();
    endtask

    task automatic t_abort();
        int d0;
        hi_pulse(MINC + 2);
        tick(4);
        chk(cal_busy == 1'b1, "R9 busy before abort", cal_busy, 1);
        d0 = n_done;
        @(negedge clk) pdcal_in = 1'b1;
        tick(2);
        chk(pwr_down == 1'b1 && cal_busy == 1'b1, "R9 busy until pd seen",
            {pwr_down, cal_busy}, 3);
        tick(1);
        chk(cal_busy == 1'b0, "R9 busy dropped", cal_busy, 0);
        @(negedge clk) pdcal_in = 1'b0;
        tick(8);
        chk(n_done == d0, "R9 no done after abort", n_done - d0, 0);
        chk({pwr_down, cal_busy} == 2'b0, "R9 idle after abort", {pwr_down, cal_busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_pd_follow();
        t_short();
        t_exact();
        t_pending();
        t_cancel();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule